// File: doc/BRIEF.md
# Sequential Binary-to-Decimal Digit Converter

This block turns an unsigned binary operand into packed decimal digits with the shift-and-add-3 procedure, doing one step per clock. A caller holds `start` high for one cycle together with the operand. The block then works through the operand bits and raises `done` for a single cycle once the digits are valid.

Shifting and correcting are kept apart. After each shift except the final one, the block looks at every decimal digit. If any digit has reached five or more, it spends one extra cycle adding three to every such digit. If no digit needs it, the next shift follows at once. The cost of a conversion therefore depends on the operand. The fastest case is one cycle per operand bit. Each correction that the value needs adds one cycle. The digit register holds the last result until the next conversion is accepted, so a display or a software-visible register can read it at any time while the block is idle.

Top module: `bcd_seq_conv`

## Requirements
- R1: A synchronous active-high `rst` leaves `busy` low, `done` low and all digits of `bcd` zero on the cycle after it is sampled.
- R2: When the block is idle, a cycle with `start` high loads `operand`, and `busy` is high from the next cycle on.
- R3: At `done`, `bcd` holds the decimal value of the operand. The hundreds digit is in bits 11:8, tens in 7:4 and ones in 3:0, and each digit lies in 0..9.
- R4: `busy` stays high for exactly 8 + K cycles, where K is the number of shifts (the final shift excluded) after which at least one digit is 5 or more. An operand of 243 takes 11 cycles.
- R5: `done` is a one-cycle pulse. It appears on the first cycle that `busy` is low after a conversion.
- R6: While `busy` is high, `start` and `operand` are ignored. The running conversion keeps its result and its cycle count.
- R7: While idle, `bcd` keeps the last result, or zero after reset, until a new `start` is accepted.
- R8: An operand whose digits never reach 5 between shifts, such as 4, finishes in exactly 8 busy cycles with no correction cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to convert `operand`; taken only when idle |
| operand | input | 8 | Unsigned binary value to convert |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| bcd | output | 12 | Three decimal digits, hundreds in the top nibble |

## Verification
The operands are 0, 4 and other small values that never trigger a correction. This separates a design that always spends correction cycles from one that adds them only on demand. The operand 243 pins both the digit values and the 11-cycle count, and 255, 200, 128, 99 and 100 cover carries across digit boundaries. A sweep of all 256 operands compares the latency and the result on every clock against a reference that runs the procedure on integers. Two further cases check that a `start` pulse with a different operand during a conversion changes neither the result nor the timing, and that a `start` on the cycle `done` is high is accepted.

// File: rtl/bcd_conv_pkg.sv
`timescale 1ns/1ps
package bcd_conv_pkg;

    localparam int DIG_W   = 4;
    localparam int FIX_MIN = 5;
    localparam int FIX_ADD = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_FIX   = 2'd2
    } conv_state_t;

endpackage

// File: rtl/bcd_digit_fix.sv
`timescale 1ns/1ps
// One decimal digit: add three when the digit is five or more.
module bcd_digit_fix
    import bcd_conv_pkg::*;
(
    input  logic [DIG_W-1:0] dig_i,
    output logic [DIG_W-1:0] dig_o
);

    always_comb begin
        if (dig_i >= DIG_W'(FIX_MIN)) begin
            dig_o = dig_i + DIG_W'(FIX_ADD);
        end else begin
            dig_o = dig_i;
        end
    end

endmodule

// File: rtl/bcd_fix_bank.sv
`timescale 1ns/1ps
// Applies the per-digit correction to a whole row of digits.
module bcd_fix_bank
    import bcd_conv_pkg::*;
#(
    parameter int N_DIG = 3
) (
    input  logic [N_DIG*DIG_W-1:0] digs_i,
    output logic [N_DIG*DIG_W-1:0] digs_o
);

    for (genvar g = 0; g < N_DIG; g++) begin : g_dig
        bcd_digit_fix fix_i (
            .dig_i (digs_i[g*DIG_W +: DIG_W]),
            .dig_o (digs_o[g*DIG_W +: DIG_W])
        );
    end

endmodule

// File: rtl/bcd_need_detect.sv
`timescale 1ns/1ps
// Flags a row of digits in which at least one digit needs correcting.
module bcd_need_detect
    import bcd_conv_pkg::*;
#(
    parameter int N_DIG = 3
) (
    input  logic [N_DIG*DIG_W-1:0] digs_i,
    output logic                   need_o
);

    logic [N_DIG-1:0] hit;

    for (genvar g = 0; g < N_DIG; g++) begin : g_dig
        assign hit[g] = (digs_i[g*DIG_W +: DIG_W] >= DIG_W'(FIX_MIN));
    end

    assign need_o = |hit;

endmodule

// File: rtl/bcd_seq_conv.sv
`timescale 1ns/1ps
// Sequential shift-and-add-3 converter, one step per clock.
module bcd_seq_conv
    import bcd_conv_pkg::*;
#(
    parameter int OP_W  = 8,
    parameter int N_DIG = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [OP_W-1:0]        operand,
    output logic                   busy,
    output logic                   done,
    output logic [N_DIG*DIG_W-1:0] bcd
);

    localparam int DIG_BITS = N_DIG * DIG_W;
    localparam int SH_W     = DIG_BITS + OP_W;
    localparam int CNT_W    = $clog2(OP_W + 1);

    typedef struct packed {
        conv_state_t      st;
        logic [SH_W-1:0]  sh;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } conv_regs_t;

    conv_regs_t r_q, r_d;

    logic [SH_W-1:0]     shifted;
    logic [DIG_BITS-1:0] fixed_digs;
    logic                need_next;

    assign shifted = r_q.sh << 1;

    bcd_fix_bank #(.N_DIG(N_DIG)) fix_bank_i (
        .digs_i (r_q.sh[SH_W-1:OP_W]),
        .digs_o (fixed_digs)
    );

    bcd_need_detect #(.N_DIG(N_DIG)) need_i (
        .digs_i (shifted[SH_W-1:OP_W]),
        .need_o (need_next)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.sh  = {{DIG_BITS{1'b0}}, operand};
                    r_d.cnt = '0;
                    r_d.st  = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                r_d.sh  = shifted;
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == CNT_W'(OP_W - 1)) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else if (need_next) begin
                    r_d.st = ST_FIX;
                end else begin
                    r_d.st = ST_SHIFT;
                end
            end
            ST_FIX: begin
                r_d.sh = {fixed_digs, r_q.sh[OP_W-1:0]};
                r_d.st = ST_SHIFT;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy = (r_q.st != ST_IDLE);
    assign done = r_q.done;
    assign bcd  = r_q.sh[SH_W-1:OP_W];

endmodule

// File: rtl/bcd_seq_conv_chk.sv
`timescale 1ns/1ps
module bcd_seq_conv_chk #(
    parameter int OP_W  = 8,
    parameter int N_DIG = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 start,
    input logic                 busy,
    input logic                 done,
    input logic [N_DIG*4-1:0]   bcd
);

    localparam int MAX_LAT = 2 * OP_W - 1;

    int unsigned busy_run;

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            busy_run <= 0;
        end else begin
            busy_run <= busy_run + 1;
        end
    end

    // R2: an idle start makes the block busy on the next cycle
    a_r2_start_loads: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    // R5: done lasts one cycle
    a_r5_done_one_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5: done only on the first idle cycle after a busy one
    a_r5_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R7: idle without start keeps the digits
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(bcd));

    // R4: conversion length is bounded by shifts plus corrections
    a_r4_busy_bounded: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_run < MAX_LAT));

    for (genvar g = 0; g < N_DIG; g++) begin : g_rng
        // R3: every digit is decimal while idle
        a_r3_digit_range: assert property (@(posedge clk) disable iff (rst)
            !busy |-> (bcd[g*4 +: 4] <= 4'd9));
    end

endmodule

bind bcd_seq_conv bcd_seq_conv_chk #(.OP_W(OP_W), .N_DIG(N_DIG)) chk_i (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .done  (done),
    .bcd   (bcd)
);

// File: tb/bcd_seq_conv_tb_top.sv
`timescale 1ns/1ps
module bcd_seq_conv_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  operand = 8'd0;
    logic        busy;
    logic        done;
    logic [11:0] bcd;

    int checks = 0;
    int bad = 0;
    int cycles = 0;

    // reference model state
    int          m_rem = 0;
    bit          m_busy = 1'b0;
    bit          m_done = 1'b0;
    logic [11:0] m_bcd = '0;
    logic [11:0] m_pend = '0;

    always #5 clk = ~clk;

    bcd_seq_conv dut_i (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .operand (operand),
        .busy    (busy),
        .done    (done),
        .bcd     (bcd)
    );

    function automatic logic [11:0] to_dec(int v);
        return {4'(v / 100), 4'((v / 10) % 10), 4'(v % 10)};
    endfunction

    // number of correction steps the procedure needs for v
    function automatic int fix_count(int v);
        logic [19:0] s;
        int k;
        s = 20'(v);
        k = 0;
        for (int i = 0; i < 8; i++) begin
            if (i > 0 && (s[19:16] >= 5 || s[15:12] >= 5 || s[11:8] >= 5)) begin
                k++;
                if (s[19:16] >= 5) s[19:16] = s[19:16] + 4'd3;
                if (s[15:12] >= 5) s[15:12] = s[15:12] + 4'd3;
                if (s[11:8]  >= 5) s[11:8]  = s[11:8]  + 4'd3;
            end
            s = s << 1;
        end
        return k;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_rem = 0; m_busy = 0; m_done = 0; m_bcd = '0;
        end else if (m_rem > 0) begin
            m_rem--;
            m_done = (m_rem == 0);
            if (m_rem == 0) begin
                m_busy = 0;
                m_bcd = m_pend;
            end
        end else begin
            m_done = 0;
            if (start) begin
                m_rem = 8 + fix_count(int'(operand));
                m_busy = 1;
                m_pend = to_dec(int'(operand));
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            check("R2/R4 busy", int'(busy), int'(m_busy));
            check("R5 done", int'(done), int'(m_done));
            if (!m_busy) check("R3/R7 bcd", int'(bcd), int'(m_bcd));
        end
    end

    initial begin
        while (cycles < 150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    task automatic convert(int v, string req);
        int n;
        @(negedge clk);
        start = 1'b1;
        operand = 8'(v);
        @(negedge clk);
        start = 1'b0;
        operand = ~operand;
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
        check(req, n, 8 + fix_count(v));
        check("R3 result", int'(bcd), int'(to_dec(v)));
        check("R5 done at end", int'(done), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 bcd", int'(bcd), 0);

        convert(0, "R8 latency 0");
        convert(4, "R8 latency 4");
        convert(243, "R4 latency 243");
        check("R4 243 is 11", 8 + fix_count(243), 11);
        convert(255, "R4 latency 255");
        convert(9, "R4 latency 9");
        convert(10, "R4 latency 10");
        convert(99, "R4 latency 99");
        convert(100, "R4 latency 100");
        convert(128, "R4 latency 128");
        convert(200, "R4 latency 200");

        // R6: start with another operand during a conversion
        @(negedge clk);
        start = 1'b1; operand = 8'd57;
        @(negedge clk);
        operand = 8'd222;
        repeat (3) @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        check("R6 result kept", int'(bcd), int'(to_dec(57)));

        // start on the done cycle is accepted
        @(negedge clk);
        start = 1'b1; operand = 8'd31;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        start = 1'b1; operand = 8'd196;
        @(negedge clk);
        start = 1'b0;
        check("R2 start on done", int'(busy), 1);
        while (busy) @(negedge clk);
        check("R3 after back-to-back", int'(bcd), int'(to_dec(196)));

        // R7: idle hold
        repeat (5) @(negedge clk);
        check("R7 hold", int'(bcd), int'(to_dec(196)));

        for (int v = 0; v < 256; v++) convert(v, "R4 sweep");

        // R1: reset mid-conversion
        @(negedge clk);
        start = 1'b1; operand = 8'd250;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid busy", int'(busy), 0);
        check("R1 mid bcd", int'(bcd), 0);
        rst = 1'b0;
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule